// File: doc/BRIEF.md
# Buffered Configuration Port Controller

This block is a memory-mapped peripheral that moves 32-bit words in either direction between a local 512-word buffer and an internal configuration port. In a configure transfer, buffer words stream out to the port. In a readback transfer, words arriving from the port are stored into the buffer. The host sees the buffer at the bottom of its address window and four control and status words above it.

The host bus is a plain single-cycle word bus. `host_addr` is a word address, so byte address B maps to word B/4. Buffer word n sits at word address n, which is byte n×4. The registers sit at word addresses 0x200 to 0x203, which are byte offsets 0x800 to 0x80C. Every host read returns its data, with `host_rvalid`, on the cycle after the request.

The host first loads a byte length and a starting word offset. It then writes the direction word, and that write starts the transfer. It polls the done bit until the transfer ends. Writing the status word aborts a running transfer.

Both port streams use valid/ready rules, and a word moves on any rising edge where valid and ready are both 1.
- Outgoing stream: once `cfg_out_valid` is raised, it and `cfg_out_data` hold until `cfg_out_ready` is seen.
- Incoming stream: `rb_in_ready` stays 1 for the whole of a readback, so the port may supply words at up to one per cycle.
- The block never asserts `cfg_out_valid` and `rb_in_ready` together.

Top module: `cfgbuf_ctrl`

## Requirements
- R1: A host write to word address n (n < 0x200) stores the data in buffer word n. A host read of that address returns the stored word on `host_rdata`, with `host_rvalid` high, on the cycle after the request.
- R2: Word 0x200 (byte 0x800) is the length register. It can be read and written, it keeps the low 12 bits of the written data as a byte count, and it reads back zero-extended. Word 0x201 (byte 0x804) is the start-offset register. It can be read and written, it keeps the low 9 bits, and it is the first buffer word the transfer uses.
- R3: A write to word 0x202 (byte 0x808) starts a transfer when the block is idle. Data bit 0 equal to 1 selects readback and 0 selects configure. Reads of this word return 0.
- R4: A configure transfer presents buffer words offset, offset+1, … in ascending order on the outgoing stream. While `cfg_out_ready` is low, `cfg_out_valid` and `cfg_out_data` stay unchanged.
- R5: During a readback, `rb_in_ready` is 1 on every cycle. Each accepted word is written to buffer words offset, offset+1, … in order, and buffer words outside that range keep their contents.
- R6: Reads of word 0x203 (byte 0x80C) return the status word:
  - bit 0: done;
  - bits 1 to 4: always 1;
  - bit 5: `port_halt_n`;
  - bit 6: `port_rb_busy`;
  - bit 7: `port_word_sync`;
  - bit 8: `port_cfg_fault`;
  - all higher bits: 0.
- R7: The done bit reads 0 from the cycle after the starting write. It reads 1 again in the cycle after the last word moves. After the last word, no further stream handshake is offered.
- R8: A direction write made while a transfer is running is ignored. The running transfer keeps its direction and its word count.
- R9: A transfer moves length/4 words, and the low two bits of the length are ignored. A length below 4 moves no word, and done stays 1.
- R10: Any host write to word 0x203 aborts a running transfer. On the next cycle done is 1 and both `cfg_out_valid` and `rb_in_ready` are 0.
- R11: After reset the following hold:
  - done is 1;
  - the length and offset registers read 0;
  - `cfg_out_valid` and `rb_in_ready` are 0.
- R12: `cfg_out_valid` and `rb_in_ready` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access request this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 10 | Host word address; bit 9 selects the registers |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid the cycle after the request |
| host_rvalid | output | 1 | Marks `host_rdata` valid |
| cfg_out_valid | output | 1 | Outgoing configure word valid |
| cfg_out_ready | input | 1 | Port accepts the outgoing word |
| cfg_out_data | output | 32 | Outgoing configure word |
| rb_in_valid | input | 1 | Incoming readback word valid |
| rb_in_ready | output | 1 | Block accepts the incoming word |
| rb_in_data | input | 32 | Incoming readback word |
| port_halt_n | input | 1 | Port abort flag, active low, reported in status |
| port_rb_busy | input | 1 | Port readback-in-progress flag, reported in status |
| port_word_sync | input | 1 | Port word-alignment flag, reported in status |
| port_cfg_fault | input | 1 | Port configuration-error flag, reported in status |

## Verification
The bench applies random back-pressure on the outgoing stream. A design that let the data move while ready was low, or that used the wrong read address after a stall, would repeat or skip a buffer word. It polls status on every cycle of a transfer. A done bit that returned a cycle early or late, or a one-word overrun when the length is not a multiple of four, shows up as a mismatch against the count of handshakes. It also covers these cases:
- A direction write during a busy configure. A design that honoured it would turn on `rb_in_ready` or restart the count.
- Lengths 0 and 3. A design that treated these as a wrapped count would stream hundreds of words.
- Status-register aborts in both directions. A design that failed to abort would keep a stream handshake offered.
- Readbacks, checked by reading the buffer back from one word before to one word after the written range. A design with an off-by-one address would change a neighbouring word.

// File: rtl/cfgbuf_pkg.sv
package cfgbuf_pkg;

  // transfer engine states
  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_PRIME = 2'd1,
    XF_SEND  = 2'd2,
    XF_RECV  = 2'd3
  } xfer_state_t;

  // register index within the control window (host_addr[1:0])
  localparam logic [1:0] IDX_LEN  = 2'd0;
  localparam logic [1:0] IDX_OFS  = 2'd1;
  localparam logic [1:0] IDX_DIR  = 2'd2;
  localparam logic [1:0] IDX_STAT = 2'd3;

  // status word bit positions
  localparam int ST_DONE  = 0;
  localparam int ST_ONE_LO = 1;
  localparam int ST_ONE_HI = 4;
  localparam int ST_HALT  = 5;
  localparam int ST_RBBSY = 6;
  localparam int ST_SYNC  = 7;
  localparam int ST_FAULT = 8;

endpackage

// File: rtl/cfgbuf_mem.sv
module cfgbuf_mem #(
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 512,
  parameter int AW        = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  // host side
  input  logic              a_en,
  input  logic              a_we,
  input  logic [AW-1:0]     a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  // engine side
  input  logic [AW-1:0]     b_raddr,
  output logic [DATA_W-1:0] b_rdata,
  input  logic              b_we,
  input  logic [AW-1:0]     b_waddr,
  input  logic [DATA_W-1:0] b_wdata
);

  logic [DATA_W-1:0] store [BUF_WORDS];

  // engine write is placed last so it wins a same-address collision
  always_ff @(posedge clk) begin
    if (a_we)         store[a_addr]  <= a_wdata;
    if (b_we)         store[b_waddr] <= b_wdata;
    if (a_en && !a_we) a_rdata       <= store[a_addr];
    b_rdata <= store[b_raddr];
  end

endmodule

// File: rtl/cfgbuf_regs.sv
module cfgbuf_regs
  import cfgbuf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int AW      = 9,
  parameter int LEN_W   = 12,
  parameter int HOST_AW = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [LEN_W-1:0]   host_wbits,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  input  logic [DATA_W-1:0]  buf_rdata,
  output logic               buf_en,
  output logic               buf_we,
  // engine control
  input  logic               xfer_done,
  output logic               xfer_start,
  output logic               xfer_rb,
  output logic               xfer_abort,
  output logic [LEN_W-3:0]   xfer_words,
  output logic [AW-1:0]      xfer_ofs,
  // raw port flags
  input  logic               port_halt_n,
  input  logic               port_rb_busy,
  input  logic               port_word_sync,
  input  logic               port_cfg_fault
);

  logic [LEN_W-1:0]  len_q;
  logic [AW-1:0]     ofs_q;
  logic [DATA_W-1:0] reg_rd_d, reg_rd_q;
  logic              rd_buf_q;
  logic              reg_hit, reg_wr;
  logic [1:0]        idx;

  always_comb begin
    reg_hit    = host_sel && host_addr[HOST_AW-1];
    idx        = host_addr[1:0];
    reg_wr     = reg_hit && host_we;
    buf_en     = host_sel && !host_addr[HOST_AW-1];
    buf_we     = buf_en && host_we;
    xfer_start = reg_wr && (idx == IDX_DIR);
    xfer_rb    = host_wbits[0];
    xfer_abort = reg_wr && (idx == IDX_STAT);
    xfer_words = len_q[LEN_W-1:2];
    xfer_ofs   = ofs_q;
  end

  always_comb begin
    reg_rd_d = '0;
    unique case (idx)
      IDX_LEN:  reg_rd_d[LEN_W-1:0] = len_q;
      IDX_OFS:  reg_rd_d[AW-1:0]    = ofs_q;
      IDX_DIR:  reg_rd_d            = '0;
      IDX_STAT: begin
        reg_rd_d[ST_DONE]             = xfer_done;
        reg_rd_d[ST_ONE_HI:ST_ONE_LO] = '1;
        reg_rd_d[ST_HALT]             = port_halt_n;
        reg_rd_d[ST_RBBSY]            = port_rb_busy;
        reg_rd_d[ST_SYNC]             = port_word_sync;
        reg_rd_d[ST_FAULT]            = port_cfg_fault;
      end
      default:  reg_rd_d            = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q       <= '0;
      ofs_q       <= '0;
      reg_rd_q    <= '0;
      rd_buf_q    <= 1'b0;
      host_rvalid <= 1'b0;
    end else begin
      if (reg_wr && idx == IDX_LEN) len_q <= host_wbits;
      if (reg_wr && idx == IDX_OFS) ofs_q <= host_wbits[AW-1:0];
      host_rvalid <= host_sel && !host_we;
      if (host_sel && !host_we) begin
        rd_buf_q <= !host_addr[HOST_AW-1];
        reg_rd_q <= reg_rd_d;
      end
    end
  end

  assign host_rdata = rd_buf_q ? buf_rdata : reg_rd_q;

  assert_len_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && idx == IDX_LEN) |=> (len_q == $past(host_wbits)));

  assert_rvalid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_sel && !host_we) |=> host_rvalid);

endmodule

// File: rtl/cfgbuf_engine.sv
module cfgbuf_engine
  import cfgbuf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 512,
  parameter int CNT_W     = 10,
  parameter int AW        = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rb,
  input  logic [CNT_W-1:0]  start_words,
  input  logic [AW-1:0]     start_ofs,
  input  logic              abort,
  output logic              done,
  // buffer engine port
  output logic [AW-1:0]     mem_raddr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  // streams
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data
);

  xfer_state_t      state_q;
  logic [AW-1:0]    ptr_q;
  logic [CNT_W-1:0] left_q;
  logic             done_q;
  logic             out_fire, in_fire, last_word;

  always_comb begin
    out_fire  = (state_q == XF_SEND) && out_ready;
    in_fire   = (state_q == XF_RECV) && in_valid;
    last_word = (left_q == CNT_W'(1));
    // read one ahead on a handshake so the next word is ready without a bubble
    mem_raddr = out_fire ? ptr_q + AW'(1) : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      ptr_q   <= '0;
      left_q  <= '0;
      done_q  <= 1'b1;
    end else if (abort) begin
      state_q <= XF_IDLE;
      done_q  <= 1'b1;
    end else begin
      unique case (state_q)
        XF_IDLE: begin
          if (start && start_words != '0) begin
            ptr_q   <= start_ofs;
            left_q  <= start_words;
            done_q  <= 1'b0;
            state_q <= start_rb ? XF_RECV : XF_PRIME;
          end
        end
        XF_PRIME: state_q <= XF_SEND;
        XF_SEND, XF_RECV: begin
          if (out_fire || in_fire) begin
            ptr_q  <= ptr_q + AW'(1);
            left_q <= left_q - CNT_W'(1);
            if (last_word) begin
              state_q <= XF_IDLE;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= XF_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign out_valid = (state_q == XF_SEND);
  assign out_data  = mem_rdata;
  assign in_ready  = (state_q == XF_RECV);
  assign mem_we    = in_fire;
  assign mem_waddr = ptr_q;
  assign mem_wdata = in_data;

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !abort) |=> out_valid);

  assert_one_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && in_ready));

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !in_ready));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (done && !out_valid && !in_ready));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != XF_IDLE) |-> (left_q != '0));

endmodule

// File: rtl/cfgbuf_ctrl.sv
module cfgbuf_ctrl #(
  parameter int DATA_W    = 32,
  parameter int BUF_WORDS = 512,
  parameter int AW        = $clog2(BUF_WORDS),
  parameter int HOST_AW   = AW + 1,
  parameter int LEN_W     = AW + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  output logic               cfg_out_valid,
  input  logic               cfg_out_ready,
  output logic [DATA_W-1:0]  cfg_out_data,
  input  logic               rb_in_valid,
  output logic               rb_in_ready,
  input  logic [DATA_W-1:0]  rb_in_data,
  input  logic               port_halt_n,
  input  logic               port_rb_busy,
  input  logic               port_word_sync,
  input  logic               port_cfg_fault
);

  localparam int CNT_W = LEN_W - 2;

  logic              buf_en, buf_we;
  logic [DATA_W-1:0] buf_rdata;
  logic              xfer_done, xfer_start, xfer_rb, xfer_abort;
  logic [CNT_W-1:0]  xfer_words;
  logic [AW-1:0]     xfer_ofs;
  logic [AW-1:0]     eng_raddr, eng_waddr;
  logic [DATA_W-1:0] eng_rdata, eng_wdata;
  logic              eng_we;

  cfgbuf_regs #(
    .DATA_W(DATA_W), .AW(AW), .LEN_W(LEN_W), .HOST_AW(HOST_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wbits(host_wdata[LEN_W-1:0]),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .buf_rdata(buf_rdata), .buf_en(buf_en), .buf_we(buf_we),
    .xfer_done(xfer_done), .xfer_start(xfer_start), .xfer_rb(xfer_rb),
    .xfer_abort(xfer_abort), .xfer_words(xfer_words), .xfer_ofs(xfer_ofs),
    .port_halt_n(port_halt_n), .port_rb_busy(port_rb_busy),
    .port_word_sync(port_word_sync), .port_cfg_fault(port_cfg_fault)
  );

  cfgbuf_mem #(
    .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS), .AW(AW)
  ) u_mem (
    .clk(clk),
    .a_en(buf_en), .a_we(buf_we), .a_addr(host_addr[AW-1:0]),
    .a_wdata(host_wdata), .a_rdata(buf_rdata),
    .b_raddr(eng_raddr), .b_rdata(eng_rdata),
    .b_we(eng_we), .b_waddr(eng_waddr), .b_wdata(eng_wdata)
  );

  cfgbuf_engine #(
    .DATA_W(DATA_W), .BUF_WORDS(BUF_WORDS), .CNT_W(CNT_W), .AW(AW)
  ) u_engine (
    .clk(clk), .rst_n(rst_n),
    .start(xfer_start), .start_rb(xfer_rb), .start_words(xfer_words),
    .start_ofs(xfer_ofs), .abort(xfer_abort), .done(xfer_done),
    .mem_raddr(eng_raddr), .mem_rdata(eng_rdata),
    .mem_we(eng_we), .mem_waddr(eng_waddr), .mem_wdata(eng_wdata),
    .out_valid(cfg_out_valid), .out_ready(cfg_out_ready), .out_data(cfg_out_data),
    .in_valid(rb_in_valid), .in_ready(rb_in_ready), .in_data(rb_in_data)
  );

endmodule

// File: tb/cfgbuf_ctrl_bench.sv
`timescale 1ns/1ps
module cfgbuf_ctrl_bench;

  localparam logic [9:0] A_LEN  = 10'h200;
  localparam logic [9:0] A_OFS  = 10'h201;
  localparam logic [9:0] A_DIR  = 10'h202;
  localparam logic [9:0] A_STAT = 10'h203;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_we = 1'b0;
  logic [9:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        cfg_out_valid, cfg_out_ready = 1'b0;
  logic [31:0] cfg_out_data;
  logic        rb_in_valid = 1'b0, rb_in_ready;
  logic [31:0] rb_in_data = '0;
  logic        port_halt_n = 1'b1, port_rb_busy = 1'b0;
  logic        port_word_sync = 1'b0, port_cfg_fault = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [512];

  always #2 clk = ~clk;

  cfgbuf_ctrl u_cfgbuf_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .cfg_out_valid(cfg_out_valid), .cfg_out_ready(cfg_out_ready),
    .cfg_out_data(cfg_out_data),
    .rb_in_valid(rb_in_valid), .rb_in_ready(rb_in_ready), .rb_in_data(rb_in_data),
    .port_halt_n(port_halt_n), .port_rb_busy(port_rb_busy),
    .port_word_sync(port_word_sync), .port_cfg_fault(port_cfg_fault)
  );

  function automatic logic [31:0] stat_word(input logic dn, input logic hn,
      input logic rb, input logic sy, input logic cf);
    return {23'd0, cf, sy, rb, hn, 4'b1111, dn};
  endfunction

  function automatic logic [31:0] stat_now(input logic dn);
    return stat_word(dn, port_halt_n, port_rb_busy, port_word_sync, port_cfg_fault);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic host_wr(input logic [9:0] a, input logic [31:0] d);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [9:0] a, output logic [31:0] d, output logic v);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_sel = 1'b0;
    d = host_rdata; v = host_rvalid;
  endtask

  task automatic rd_chk(input logic [9:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d; logic v;
    host_rd(a, d, v);
    chk(v && d == exp, req, d, exp);
  endtask

  // drain a configure of cnt words from off; polls status every cycle
  task automatic drain_cfg(input int off, input int cnt);
    int hs = 0; bit pend = 0; bit stalled = 0; logic [31:0] held = '0; bit rdy;
    for (int cyc = 0; cyc < 20000 && hs < cnt; cyc++) begin
      if (pend) chk(host_rvalid && host_rdata == stat_now(1'b0), "R7 busy done=0",
                    host_rdata, stat_now(1'b0));
      host_sel = 1'b1; host_we = 1'b0; host_addr = A_STAT; pend = 1;
      chk(!rb_in_ready, "R12/R8 no readback during configure", 32'(rb_in_ready), 0);
      if (stalled) chk(cfg_out_valid && cfg_out_data == held, "R4 hold under stall",
                       cfg_out_data, held);
      rdy = ($urandom % 4) != 0;
      cfg_out_ready = rdy;
      if (cfg_out_valid && rdy) begin
        chk(cfg_out_data == model[off + hs], "R4 word order", cfg_out_data, model[off + hs]);
        hs++;
      end
      stalled = cfg_out_valid && !rdy;
      held = cfg_out_data;
      @(negedge clk);
    end
    chk(hs == cnt, "R9 word count", 32'(hs), 32'(cnt));
    cfg_out_ready = 1'b0;
    chk(host_rdata == stat_now(1'b0), "R7 done=0 in last-word cycle", host_rdata, stat_now(1'b0));
    @(negedge clk);
    host_sel = 1'b0;
    chk(host_rdata == stat_now(1'b1), "R7 done=1 after last word", host_rdata, stat_now(1'b1));
    chk(!cfg_out_valid, "R7 no valid after end", 32'(cfg_out_valid), 0);
  endtask

  task automatic run_cfg(input int off, input int cnt, input int lo);
    host_wr(A_LEN, 32'(cnt * 4 + lo));
    host_wr(A_OFS, 32'(off));
    host_wr(A_DIR, 32'd0);
    drain_cfg(off, cnt);
  endtask

  task automatic run_rb(input int off, input int cnt);
    int hs = 0; bit pend = 0; bit v;
    host_wr(A_LEN, 32'(cnt * 4 + ($urandom % 4)));
    host_wr(A_OFS, 32'(off));
    host_wr(A_DIR, 32'd1);
    for (int cyc = 0; cyc < 20000 && hs < cnt; cyc++) begin
      if (pend) chk(host_rdata == stat_now(1'b0), "R7 readback done=0", host_rdata, stat_now(1'b0));
      host_sel = 1'b1; host_we = 1'b0; host_addr = A_STAT; pend = 1;
      chk(rb_in_ready, "R5 ready held", 32'(rb_in_ready), 1);
      chk(!cfg_out_valid, "R12 no configure during readback", 32'(cfg_out_valid), 0);
      v = ($urandom % 3) != 0;
      rb_in_valid = v;
      rb_in_data = $urandom;
      if (v && rb_in_ready) begin
        model[off + hs] = rb_in_data;
        hs++;
      end
      @(negedge clk);
    end
    rb_in_valid = 1'b0;
    host_sel = 1'b0;
    chk(!rb_in_ready, "R7 readback ends", 32'(rb_in_ready), 0);
    for (int i = (off > 0 ? off - 1 : 0); i <= (off + cnt < 512 ? off + cnt : 511); i++)
      rd_chk(10'(i), model[i], "R5 buffer after readback");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] d; logic v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(!cfg_out_valid && !rb_in_ready, "R11 streams idle", {cfg_out_valid, rb_in_ready}, 0);
    rd_chk(A_LEN, 32'd0, "R11 length reset");
    rd_chk(A_OFS, 32'd0, "R11 offset reset");
    rd_chk(A_STAT, stat_now(1'b1), "R11 done after reset");

    // R1 buffer fill and random readback
    for (int i = 0; i < 512; i++) begin
      model[i] = $urandom;
      host_wr(10'(i), model[i]);
    end
    for (int k = 0; k < 16; k++) begin
      int a = $urandom % 512;
      rd_chk(10'(a), model[a], "R1 buffer read");
    end
    rd_chk(10'd0, model[0], "R1 first word");
    rd_chk(10'd511, model[511], "R1 last word");

    // R2 register readback, R3 direction reads zero
    host_wr(A_LEN, 32'hFFFF_F5A7);
    rd_chk(A_LEN, 32'h0000_05A7, "R2 length keeps 12 bits");
    host_wr(A_OFS, 32'hFFFF_FF3C);
    rd_chk(A_OFS, 32'h0000_013C, "R2 offset keeps 9 bits");
    rd_chk(A_DIR, 32'd0, "R3 direction reads zero");

    // R4 R7 R9 configure runs, including low length bits
    run_cfg(10, 8, 0);
    run_cfg(0, 1, 3);
    run_cfg(504, 8, 2);
    for (int k = 0; k < 4; k++) begin
      int cnt = 1 + ($urandom % 40);
      int off = $urandom % (512 - cnt + 1);
      run_cfg(off, cnt, $urandom % 4);
    end

    // R5 readback runs
    run_rb(37, 12);
    run_rb(0, 1);
    for (int k = 0; k < 3; k++) begin
      int cnt = 1 + ($urandom % 30);
      int off = $urandom % (512 - cnt + 1);
      run_rb(off, cnt);
    end
    // configure what was read back
    run_cfg(37, 12, 0);

    // R8 direction write while busy is ignored
    cfg_out_ready = 1'b0;
    host_wr(A_LEN, 32'd20);
    host_wr(A_OFS, 32'd100);
    host_wr(A_DIR, 32'd0);
    @(negedge clk);
    host_wr(A_LEN, 32'd200);
    host_wr(A_DIR, 32'd1);
    chk(!rb_in_ready && cfg_out_valid, "R8 busy start ignored", {rb_in_ready, cfg_out_valid}, 32'd1);
    drain_cfg(100, 5);

    // R9 lengths below one word
    host_wr(A_LEN, 32'd0);
    host_wr(A_DIR, 32'd0);
    chk(!cfg_out_valid, "R9 zero length no stream", 32'(cfg_out_valid), 0);
    rd_chk(A_STAT, stat_now(1'b1), "R9 zero length done");
    host_wr(A_LEN, 32'd3);
    host_wr(A_DIR, 32'd1);
    chk(!rb_in_ready, "R9 length 3 no readback", 32'(rb_in_ready), 0);
    @(negedge clk);
    chk(!rb_in_ready && !cfg_out_valid, "R9 stays idle", {rb_in_ready, cfg_out_valid}, 0);
    rd_chk(A_STAT, stat_now(1'b1), "R9 length 3 done");

    // R10 abort during configure and readback
    host_wr(A_LEN, 32'd80);
    host_wr(A_OFS, 32'd0);
    host_wr(A_DIR, 32'd0);
    repeat (3) @(negedge clk);
    chk(cfg_out_valid, "R10 configure running", 32'(cfg_out_valid), 1);
    host_wr(A_STAT, 32'h0000_FEFE);
    chk(!cfg_out_valid && !rb_in_ready, "R10 abort configure", {cfg_out_valid, rb_in_ready}, 0);
    rd_chk(A_STAT, stat_now(1'b1), "R10 done after abort");
    host_wr(A_DIR, 32'd1);
    chk(rb_in_ready, "R10 readback running", 32'(rb_in_ready), 1);
    host_wr(A_STAT, 32'd0);
    chk(!rb_in_ready && !cfg_out_valid, "R10 abort readback", {rb_in_ready, cfg_out_valid}, 0);
    rd_chk(A_STAT, stat_now(1'b1), "R10 done after readback abort");

    // R6 status flag mapping
    for (int k = 0; k < 8; k++) begin
      port_halt_n = 1'($urandom); port_rb_busy = 1'($urandom);
      port_word_sync = 1'($urandom); port_cfg_fault = 1'($urandom);
      rd_chk(A_STAT, stat_word(1'b1, port_halt_n, port_rb_busy, port_word_sync,
                               port_cfg_fault), "R6 status layout");
    end
    port_halt_n = 1'b0; port_rb_busy = 1'b1; port_word_sync = 1'b1; port_cfg_fault = 1'b1;
    host_rd(A_STAT, d, v);
    chk(v && d == 32'h0000_01DF, "R6 all flags", d, 32'h0000_01DF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule